// File: doc/BRIEF.md
# Linked-List Coherence Home Directory

This block is the home-node directory controller for a flat, cache-based coherence scheme. Each shareable memory block mapped to this home has one directory entry. The entry holds a state (Uncached, Shared or Exclusive-Modified) and a pointer to the head of that block's sharer list. No sharer bit-vector is kept. The sharers link themselves into a doubly linked list on the cache side. The directory only tracks who is at the front of that list.

A miss request carries an operation, a requestor node ID and an address. The address splits as `{home_id, block_index}`: the upper `HOME_W` bits choose the home node and the lower `BLK_W` bits choose the entry. For a miss, the directory answers in one of two ways. If the block had no sharers, it tells the requestor to take the data from memory. Otherwise it returns the ID of the old list head, so that the requestor can splice itself in front of that node (on a read) or walk the list and invalidate the other copies (on a write). In both cases the requestor becomes the new head.

A replacement message from the node at the head of the list returns the entry to Uncached. Only one request is in flight at a time. Requests and responses each use a valid/ready handshake.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is Uncached with a null (zero) head pointer; `req_ready` is 1, and `rsp_valid` and `busy` are 0.
- R2: A read miss (op 0) to an Uncached entry answers kind 0 (data from memory) with `rsp_node` 0. The entry becomes Shared with the requestor as head. `rsp_dst` always carries the requestor ID.
- R3: A read miss to a Shared or Exclusive-Modified entry answers kind 1 (head ID) with the old head in `rsp_node`. The entry becomes Shared with the requestor as head.
- R4: A write miss (op 1) to an Uncached entry answers kind 0 with `rsp_node` 0. The entry becomes Exclusive-Modified with the requestor as head.
- R5: A write miss to a Shared or Exclusive-Modified entry answers kind 1 with the old head, even when that head is the requestor. The entry becomes Exclusive-Modified with the requestor as head.
- R6: A request whose upper address bits differ from `HOME_ID` answers kind 3 (reject) and leaves every entry unchanged.
- R7: A replacement (op 2) from the current head of a non-Uncached entry answers kind 2 (acknowledge) and makes the entry Uncached with a null head. A replacement from any other node, or to an Uncached entry, answers kind 3 and changes nothing.
- R8: The reserved op 3 answers kind 3 and changes nothing.
- R9: While a request is being handled, it is handled alone. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From that edge, `busy` is 1 and `req_ready` is 0 until the edge on which the response is accepted. `rsp_valid` rises two edges after acceptance.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_kind`, `rsp_node` and `rsp_dst` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 replacement, 3 reserved |
| req_node | input | NODE_W | Requestor node ID |
| req_addr | input | HOME_W+BLK_W | {home_id, block_index} |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 data, 1 head ID, 2 acknowledge, 3 reject |
| rsp_node | output | NODE_W | Old list head (kind 1), else 0 |
| rsp_dst | output | NODE_W | Requestor the response goes to |
| busy | output | 1 | A request is in flight |

## Verification
Directed sequences drive one block through every state: a first read, a second read, a write by a new node, a write by the node already at the head, a replacement from a non-head node and one from the head. These show whether the returned head is the old one, and whether the next state depends on the old state or only on the op. Wrong-home requests and reserved-op requests are each followed by a read of the same block, which shows at the ports whether an entry was touched. Random mixes of all ops, with replacements biased toward the true head and varying response back-pressure, are checked against a bench model of every entry. They expose stale entries, entries aliased across indices, and responses that drift while stalled.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXM = 2'd2} dstate_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_REPL = 2'd2, OP_RSV = 2'd3} dop_t;
  typedef enum logic [1:0] {RK_DATA = 2'd0, RK_HEAD = 2'd1, RK_ACK = 2'd2, RK_NACK = 2'd3} rkind_t;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
  parameter int NODE_W = 4,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [BLK_W-1:0]  rd_idx,
  output logic [1:0]        rd_state,
  output logic [NODE_W-1:0] rd_head,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_idx,
  input  logic [1:0]        wr_state,
  input  logic [NODE_W-1:0] wr_head
);
  localparam int DEPTH = 1 << BLK_W;
  localparam int EW    = 2 + NODE_W;

  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    rd_q;
  logic [DEPTH-1:0] live;
  logic             live_q;

  // Plain array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_state, wr_head};
    if (rd_en) rd_q <= mem[rd_idx];
  end

  // Per-entry live flags give an instant reset to Uncached.
  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      live_q <= 1'b0;
    end else begin
      if (wr_en) live[wr_idx] <= (wr_state != coh_dir_pkg::DS_UNC);
      if (rd_en) live_q <= live[rd_idx];
    end
  end

  assign rd_state = live_q ? rd_q[EW-1 -: 2] : coh_dir_pkg::DS_UNC;
  assign rd_head  = live_q ? rd_q[NODE_W-1:0] : '0;

  // R1: an Uncached entry never shows a non-null head
  assert_unc_null_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_state == coh_dir_pkg::DS_UNC) |-> (rd_head == '0));
endmodule

// File: rtl/coh_dir_next.sv
module coh_dir_next #(
  parameter int NODE_W = 4
) (
  input  logic [1:0]        op,
  input  logic [NODE_W-1:0] node,
  input  logic              home_ok,
  input  logic [1:0]        cur_state,
  input  logic [NODE_W-1:0] cur_head,
  output logic [1:0]        kind,
  output logic [NODE_W-1:0] ret_node,
  output logic              upd,
  output logic [1:0]        nxt_state,
  output logic [NODE_W-1:0] nxt_head
);
  import coh_dir_pkg::*;

  logic unc;
  assign unc = (cur_state == DS_UNC);

  always_comb begin
    kind      = RK_NACK;
    ret_node  = '0;
    upd       = 1'b0;
    nxt_state = cur_state;
    nxt_head  = cur_head;
    if (home_ok) begin
      unique case (dop_t'(op))
        OP_RD, OP_WR: begin
          upd       = 1'b1;
          nxt_head  = node;
          nxt_state = (op == OP_WR) ? DS_EXM : DS_SHR;
          kind      = unc ? RK_DATA : RK_HEAD;
          ret_node  = unc ? '0 : cur_head;
        end
        OP_REPL: begin
          if (!unc && cur_head == node) begin
            upd       = 1'b1;
            kind      = RK_ACK;
            nxt_state = DS_UNC;
            nxt_head  = '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir #(
  parameter int NODE_W  = 4,
  parameter int BLK_W   = 4,
  parameter int HOME_W  = 2,
  parameter int HOME_ID = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [NODE_W-1:0]       req_node,
  input  logic [HOME_W+BLK_W-1:0] req_addr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [1:0]              rsp_kind,
  output logic [NODE_W-1:0]       rsp_node,
  output logic [NODE_W-1:0]       rsp_dst,
  output logic                    busy
);
  localparam int AW = HOME_W + BLK_W;
  localparam logic [HOME_W-1:0] MY_HOME = HOME_W'(HOME_ID);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_RESP} fsm_t;
  fsm_t st;

  logic [1:0]        op_q;
  logic [NODE_W-1:0] node_q;
  logic [BLK_W-1:0]  idx_q;
  logic              home_q;
  logic              accept;
  logic [1:0]        cur_state, nxt_state, kind;
  logic [NODE_W-1:0] cur_head, nxt_head, ret_node;
  logic              upd;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  coh_dir_store #(.NODE_W(NODE_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_idx(req_addr[BLK_W-1:0]),
    .rd_state(cur_state), .rd_head(cur_head),
    .wr_en(st == ST_LOOK && upd), .wr_idx(idx_q),
    .wr_state(nxt_state), .wr_head(nxt_head)
  );

  coh_dir_next #(.NODE_W(NODE_W)) u_next (
    .op(op_q), .node(node_q), .home_ok(home_q),
    .cur_state(cur_state), .cur_head(cur_head),
    .kind(kind), .ret_node(ret_node), .upd(upd),
    .nxt_state(nxt_state), .nxt_head(nxt_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_node  <= '0;
      rsp_dst   <= '0;
      op_q      <= '0;
      node_q    <= '0;
      idx_q     <= '0;
      home_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_LOOK;
          busy   <= 1'b1;
          op_q   <= req_op;
          node_q <= req_node;
          idx_q  <= req_addr[BLK_W-1:0];
          home_q <= (req_addr[AW-1 -: HOME_W] == MY_HOME);
        end
        ST_LOOK: begin
          st        <= ST_RESP;
          rsp_valid <= 1'b1;
          rsp_kind  <= kind;
          rsp_node  <= ret_node;
          rsp_dst   <= node_q;
        end
        default: if (rsp_ready) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b0;
          busy      <= 1'b0;
        end
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_node) && $stable(rsp_dst)));
  assert_single_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
  assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!req_ready && !rsp_valid));
  assert_lat_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 rsp_valid);
  assert_data_null_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == coh_dir_pkg::RK_DATA) |-> (rsp_node == '0));
endmodule

// File: tb/coh_home_dir_bench.sv
module coh_home_dir_bench;
  localparam int NODE_W = 4, BLK_W = 4, HOME_W = 2, HOME_ID = 1;
  localparam int DEPTH = 1 << BLK_W;

  logic clk = 0, rst = 1;
  logic req_valid = 0, rsp_ready = 0;
  logic [1:0] req_op = 0;
  logic [NODE_W-1:0] req_node = 0;
  logic [HOME_W+BLK_W-1:0] req_addr = 0;
  logic req_ready, rsp_valid, busy;
  logic [1:0] rsp_kind;
  logic [NODE_W-1:0] rsp_node, rsp_dst;

  int total = 0, bad = 0;
  bit done = 0;
  int mst [DEPTH];
  int mhd [DEPTH];

  always #4 clk = ~clk;

  coh_home_dir #(.NODE_W(NODE_W), .BLK_W(BLK_W), .HOME_W(HOME_W), .HOME_ID(HOME_ID)) u_coh_home_dir (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_node(req_node), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_node(rsp_node), .rsp_dst(rsp_dst), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model: state 0 Uncached, 1 Shared, 2 Exclusive-Modified
  task automatic model(input int op, input int nd, input int ad, output int k, output int rn);
    int idx = ad % DEPTH;
    bit home = (ad / DEPTH) == HOME_ID;
    k = 3; rn = 0;
    if (!home) return;
    if (op == 0 || op == 1) begin
      k  = (mst[idx] == 0) ? 0 : 1;
      rn = (mst[idx] == 0) ? 0 : mhd[idx];
      mst[idx] = (op == 1) ? 2 : 1;
      mhd[idx] = nd;
    end else if (op == 2 && mst[idx] != 0 && mhd[idx] == nd) begin
      k = 2; mst[idx] = 0; mhd[idx] = 0;
    end
  endtask

  task automatic send(input int op, input int nd, input int ad, input int hold, input string tag);
    int ek, en;
    logic [1:0] k0;
    logic [NODE_W-1:0] n0, d0;
    model(op, nd, ad, ek, en);
    @(negedge clk);
    chk(req_ready == 1, "R9 ready when idle", int'(req_ready), 1);
    req_valid = 1; req_op = 2'(op); req_node = NODE_W'(nd); req_addr = (HOME_W+BLK_W)'(ad);
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready && !rsp_valid, "R9 busy after accept", int'({busy, req_ready, rsp_valid}), 4);
    @(negedge clk);
    chk(rsp_valid == 1, "R9 response two edges after accept", int'(rsp_valid), 1);
    k0 = rsp_kind; n0 = rsp_node; d0 = rsp_dst;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_kind == k0 && rsp_node == n0 && rsp_dst == d0 && !req_ready,
          "R10 stalled response stable", int'({rsp_kind, rsp_node}), int'({k0, n0}));
    end
    chk(int'(rsp_kind) == ek, {tag, " kind"}, int'(rsp_kind), ek);
    chk(int'(rsp_node) == en, {tag, " node"}, int'(rsp_node), en);
    chk(int'(rsp_dst) == nd, "R2 dst echoes requestor", int'(rsp_dst), nd);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready && !busy && !rsp_valid, "R9 free after response", int'({req_ready, busy, rsp_valid}), 4);
  endtask

  localparam int B = HOME_ID * DEPTH;

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < DEPTH; i++) begin mst[i] = 0; mhd[i] = 0; end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !busy, "R1 reset outputs", int'({req_ready, rsp_valid, busy}), 4);
    send(0, 3, B + 15, 0, "R1 first touch uncached");
    send(0, 5, B + 2, 0, "R2 read uncached");
    send(0, 7, B + 2, 2, "R3 read shared");
    send(1, 9, B + 2, 0, "R5 write shared");
    send(0, 4, B + 2, 1, "R3 read exclusive");
    send(1, 4, B + 2, 0, "R5 write by own head");
    send(2, 7, B + 2, 0, "R7 replace non-head");
    send(2, 4, B + 2, 0, "R7 replace from head");
    send(0, 6, B + 2, 0, "R7 read after replace");
    send(2, 6, B + 9, 0, "R7 replace uncached");
    send(1, 8, B + 9, 0, "R4 write uncached");
    send(0, 1, 0 * DEPTH + 9, 0, "R6 wrong home");
    send(1, 2, 3 * DEPTH + 9, 3, "R6 wrong home write");
    send(3, 2, B + 9, 0, "R8 reserved op");
    send(0, 10, B + 9, 0, "R6 R8 entry unchanged");
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 4;
      int ad = ((($urandom % 8) == 0) ? ($urandom % 4) : HOME_ID) * DEPTH + ($urandom % DEPTH);
      int nd = $urandom % 16;
      if (op == 3 && ($urandom % 3) != 0) op = $urandom % 2;
      if (op == 2 && ($urandom % 2) == 0) nd = mhd[ad % DEPTH];
      send(op, nd, ad, $urandom % 3, "R3 R5 R7 random mix");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule